// File: doc/BRIEF.md
# Multi-Size Integer Inverse Transform Engine

This block turns a block of signed 16-bit transform coefficients back into residual samples with a two-pass separable integer inverse transform. It holds an 8x8 coefficient array internally. The array is filled through a valid/ready load stream in raster order. A start pulse then picks one region to transform: the full 8x8 array, an 8-wide by 4-tall half, a 4-wide by 8-tall half, or a 4x4 quarter. The engine first transforms every row of that region, then every column, and writes each result back in place. Words outside the region are not touched.

When the work ends, a one-cycle done pulse is raised and all 64 words are offered on a valid/ready unload stream, also in raster order. The unload stream honours back-pressure. While `ul_valid` is high and `ul_ready` is low, `ul_data` holds its value. Each word leaves only on a cycle where both are high. The load stream accepts data only while the engine is idle (`ld_ready` high). A beat moves on a cycle where `ld_valid` and `ld_ready` are both high. Rows and columns go through a single shared kernel, one line per clock cycle.

Top module: `itx_core`

## Requirements
- R1: After reset, `ld_ready` is high only while the engine is idle. It is low while transforming and while unloading. Accepted beats go to raster positions 0,1,2,… (row = index/8, column = index%8). The position counter returns to 0 on every accepted start.
- R2: `size_sel`=0 (full 8x8). Each row gets the 8-point kernel with +4 and an arithmetic shift right by 3. Each column then gets the 8-point kernel with +64 and a shift by 7, and outputs 4..7 of each column add a further +1 before the shift. 8-point kernel: e0=12(x0+x4), e1=12(x0−x4), e2=16x2+6x6, e3=6x2−16x6. Odd sums use weights (16,15,9,4), (15,−4,−16,−9), (9,−16,4,15) and (4,−9,15,−16) on x1,x3,x5,x7. Outputs 0..3 are (e0+e2, e1+e3, e1−e3, e0−e2) plus odd sums 0..3. Outputs 7..4 are the same even values minus odd sums 0..3.
- R3: `size_sel`=1 (8 wide, 4 tall, starting at row 4·`sub_idx[0]`). Rows use the 8-point kernel with row rounding. Columns use the 4-point kernel with +64 and a shift by 7, and get no extra bias. 4-point kernel: p=17(x0+x2), q=17(x0−x2). The outputs are p+22x1+10x3, q+10x1−22x3, q−10x1+22x3 and p−22x1−10x3.
- R4: `size_sel`=2 (4 wide, 8 tall, starting at column 4·`sub_idx[0]`). Rows use the 4-point kernel with +4 and a shift by 3. Columns use the 8-point kernel with column rounding, including the +1 on outputs 4..7.
- R5: `size_sel`=3 (4x4). `sub_idx[0]` picks the column half and `sub_idx[1]` the row half. Both passes use the 4-point kernel.
- R6: Array words outside the selected region are unloaded with the values that were loaded.
- R7: `done` rises exactly H+W clock edges after the edge that samples start (H rows plus W columns), and it lasts one cycle. `busy` is high from the cycle after start until done.
- R8: After done, the 64 words are unloaded in raster order. `ul_data` is held while `ul_valid` is high and `ul_ready` is low. After the 64th transfer the engine is idle, with `ul_valid` low and `ld_ready` high.
- R9: A start pulse while the engine is busy or unloading is ignored, together with its size and sub-block inputs.
- R10: Row-pass results and final results are truncated to 16 bits with no saturation. Overflow wraps modulo 2^16.
- R11: After reset, `busy`, `done` and `ul_valid` are low and `ld_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transform (sampled only when idle) |
| size_sel | input | 2 | Region shape: 0 full, 1 8-wide half, 2 4-wide half, 3 quarter |
| sub_idx | input | 2 | Sub-block index for the region |
| busy | output | 1 | Row or column pass in progress |
| done | output | 1 | One-cycle pulse when the transform ends |
| ld_valid | input | 1 | Load beat valid |
| ld_ready | output | 1 | Engine accepts load beats |
| ld_data | input | 16 | Signed coefficient in |
| ul_valid | output | 1 | Unload word valid |
| ul_ready | input | 1 | Downstream accepts unload word |
| ul_data | output | 16 | Signed result out |

## Verification
Each pass line takes one cycle. So done is due H+W edges after the start edge: 16 for the full block, 12 for the halves and 8 for the quarter. The bench counts edges from start and checks done at exactly that count. It drives and samples on the falling edge, so a load beat or unload word counts as transferred only if both valid and ready were high just before the next rising edge. Unload words are taken on those cycles only, under an irregular ready pattern. Each stalled cycle is checked to show the same word again.

// File: rtl/itx_pkg.sv
package itx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ROWS  = 2'd1,
    ST_COLS  = 2'd2,
    ST_DRAIN = 2'd3
  } itx_state_e;

  typedef enum logic [1:0] {
    SZ_FULL  = 2'd0,
    SZ_WIDE  = 2'd1,
    SZ_TALL  = 2'd2,
    SZ_QUART = 2'd3
  } itx_size_e;

  localparam int unsigned SIDE   = 8;
  localparam int unsigned HALF   = SIDE / 2;
  localparam int unsigned CELLS  = SIDE * SIDE;
  localparam int unsigned IDX_W  = $clog2(SIDE);
  localparam int unsigned ADDR_W = $clog2(CELLS);
endpackage

// File: rtl/itx_kernel.sv
module itx_kernel #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 32
) (
  input  logic signed [DW-1:0] x [8],
  input  logic                 wide8,
  input  logic                 col_pass,
  output logic signed [DW-1:0] y [8]
);
  localparam int ROW_RND = 4;
  localparam int ROW_SH  = 3;
  localparam int COL_RND = 64;
  localparam int COL_SH  = 7;

  logic signed [AW-1:0] s [8];
  logic signed [AW-1:0] e0, e1, e2, e3, a0, a1, a2, a3;
  logic signed [AW-1:0] o0, o1, o2, o3, p, q;
  logic signed [AW-1:0] rnd, lo_bias;
  int unsigned sh;

  for (genvar i = 0; i < 8; i++) begin : g_ext
    assign s[i] = AW'(x[i]);
  end

  always_comb begin
    rnd     = col_pass ? AW'(COL_RND) : AW'(ROW_RND);
    sh      = col_pass ? COL_SH : ROW_SH;
    lo_bias = (col_pass && wide8) ? AW'(1) : AW'(0);
    e0 = 12 * (s[0] + s[4]);
    e1 = 12 * (s[0] - s[4]);
    e2 = 16 * s[2] + 6 * s[6];
    e3 = 6 * s[2] - 16 * s[6];
    a0 = e0 + e2;
    a1 = e1 + e3;
    a2 = e1 - e3;
    a3 = e0 - e2;
    o0 = 16 * s[1] + 15 * s[3] + 9 * s[5] + 4 * s[7];
    o1 = 15 * s[1] - 4 * s[3] - 16 * s[5] - 9 * s[7];
    o2 = 9 * s[1] - 16 * s[3] + 4 * s[5] + 15 * s[7];
    o3 = 4 * s[1] - 9 * s[3] + 15 * s[5] - 16 * s[7];
    p  = 17 * (s[0] + s[2]);
    q  = 17 * (s[0] - s[2]);
    if (wide8) begin
      y[0] = DW'((a0 + o0 + rnd) >>> sh);
      y[1] = DW'((a1 + o1 + rnd) >>> sh);
      y[2] = DW'((a2 + o2 + rnd) >>> sh);
      y[3] = DW'((a3 + o3 + rnd) >>> sh);
      y[4] = DW'((a3 - o3 + rnd + lo_bias) >>> sh);
      y[5] = DW'((a2 - o2 + rnd + lo_bias) >>> sh);
      y[6] = DW'((a1 - o1 + rnd + lo_bias) >>> sh);
      y[7] = DW'((a0 - o0 + rnd + lo_bias) >>> sh);
    end else begin
      y[0] = DW'((p + 22 * s[1] + 10 * s[3] + rnd) >>> sh);
      y[1] = DW'((q + 10 * s[1] - 22 * s[3] + rnd) >>> sh);
      y[2] = DW'((q - 10 * s[1] + 22 * s[3] + rnd) >>> sh);
      y[3] = DW'((p - 22 * s[1] - 10 * s[3] + rnd) >>> sh);
      y[4] = '0;
      y[5] = '0;
      y[6] = '0;
      y[7] = '0;
    end
  end
endmodule

// File: rtl/itx_ctrl.sv
module itx_ctrl
  import itx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        size_sel,
  input  logic [1:0]        sub_idx,
  input  logic              ld_fire,
  input  logic              ul_fire,
  output itx_state_e        state,
  output logic [IDX_W-1:0]  line,
  output logic [IDX_W-1:0]  r0,
  output logic [IDX_W-1:0]  c0,
  output logic              rows8,
  output logic              cols8,
  output logic [ADDR_W-1:0] wr_ptr,
  output logic [ADDR_W-1:0] rd_ptr,
  output logic              done
);
  logic [1:0] sz_q, sb_q;
  logic [IDX_W-1:0] h_last, w_last;

  always_comb begin
    cols8  = ~sz_q[0];
    rows8  = ~sz_q[1];
    h_last = cols8 ? IDX_W'(SIDE - 1) : IDX_W'(HALF - 1);
    w_last = rows8 ? IDX_W'(SIDE - 1) : IDX_W'(HALF - 1);
    r0     = sz_q[0] ? ((sz_q[1] ? sb_q[1] : sb_q[0]) ? IDX_W'(HALF) : '0) : '0;
    c0     = (sz_q[1] && sb_q[0]) ? IDX_W'(HALF) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      line   <= '0;
      sz_q   <= '0;
      sb_q   <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            sz_q   <= size_sel;
            sb_q   <= sub_idx;
            line   <= '0;
            wr_ptr <= '0;
            state  <= ST_ROWS;
          end else if (ld_fire) begin
            wr_ptr <= wr_ptr + 1'b1;
          end
        end
        ST_ROWS: begin
          if (line == h_last) begin
            line  <= '0;
            state <= ST_COLS;
          end else begin
            line <= line + 1'b1;
          end
        end
        ST_COLS: begin
          if (line == w_last) begin
            line   <= '0;
            rd_ptr <= '0;
            done   <= 1'b1;
            state  <= ST_DRAIN;
          end else begin
            line <= line + 1'b1;
          end
        end
        ST_DRAIN: begin
          if (ul_fire) begin
            rd_ptr <= rd_ptr + 1'b1;
            if (rd_ptr == ADDR_W'(CELLS - 1)) state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/itx_core.sv
module itx_core
  import itx_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    size_sel,
  input  logic [1:0]    sub_idx,
  output logic          busy,
  output logic          done,
  input  logic          ld_valid,
  output logic          ld_ready,
  input  logic [DW-1:0] ld_data,
  output logic          ul_valid,
  input  logic          ul_ready,
  output logic [DW-1:0] ul_data
);
  itx_state_e        state;
  logic [IDX_W-1:0]  line, r0, c0;
  logic              rows8, cols8, col_pass, wide8, step;
  logic [ADDR_W-1:0] wr_ptr, rd_ptr;
  logic              ld_fire, ul_fire;
  logic signed [DW-1:0] mem [CELLS];
  logic signed [DW-1:0] kin [8];
  logic signed [DW-1:0] kout [8];
  logic [ADDR_W-1:0]    addr [8];

  assign ld_ready = (state == ST_IDLE);
  assign ul_valid = (state == ST_DRAIN);
  assign busy     = (state == ST_ROWS) || (state == ST_COLS);
  assign ld_fire  = ld_valid && ld_ready;
  assign ul_fire  = ul_valid && ul_ready;
  assign col_pass = (state == ST_COLS);
  assign wide8    = col_pass ? cols8 : rows8;
  assign step     = busy;
  assign ul_data  = mem[rd_ptr];

  itx_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .size_sel (size_sel),
    .sub_idx  (sub_idx),
    .ld_fire  (ld_fire),
    .ul_fire  (ul_fire),
    .state    (state),
    .line     (line),
    .r0       (r0),
    .c0       (c0),
    .rows8    (rows8),
    .cols8    (cols8),
    .wr_ptr   (wr_ptr),
    .rd_ptr   (rd_ptr),
    .done     (done)
  );

  for (genvar k = 0; k < 8; k++) begin : g_lane
    logic [IDX_W-1:0] rr, cc;
    assign rr      = r0 + (col_pass ? IDX_W'(k) : line);
    assign cc      = c0 + (col_pass ? line : IDX_W'(k));
    assign addr[k] = {rr, cc};
    assign kin[k]  = mem[addr[k]];
  end

  itx_kernel #(.DW(DW), .AW(AW)) u_kernel (
    .x        (kin),
    .wide8    (wide8),
    .col_pass (col_pass),
    .y        (kout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CELLS; i++) mem[i] <= '0;
    end else if (ld_fire && !start) begin
      mem[wr_ptr] <= ld_data;
    end else if (step) begin
      for (int k = 0; k < 8; k++) begin
        if (wide8 || k < HALF) mem[addr[k]] <= kout[k];
      end
    end
  end
endmodule

// File: rtl/itx_core_chk.sv
module itx_core_chk #(
  parameter int unsigned DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          ld_ready,
  input logic          ul_valid,
  input logic          ul_ready,
  input logic [DW-1:0] ul_data
);
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_done_drain: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ul_valid && !busy));
  a_r8_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    (ul_valid && !ul_ready) |=> (ul_valid && $stable(ul_data)));
  a_r1_no_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || ul_valid) |-> !ld_ready);
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));
  a_r8_drain_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (ul_valid && !ul_ready) |=> !ld_ready);
endmodule

bind itx_core itx_core_chk #(.DW(DW)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .ld_ready (ld_ready),
  .ul_valid (ul_valid),
  .ul_ready (ul_ready),
  .ul_data  (ul_data)
);

// File: tb/itx_core_tb_top.sv
module itx_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;
  // {size[7:6], sub[5:4], pattern[3:0]}
  localparam logic [7:0] VEC [NVEC] = '{
    8'h00, 8'h01, 8'h02, 8'h04, 8'h43, 8'h51, 8'h82,
    8'h93, 8'hC1, 8'hD2, 8'hE3, 8'hF4, 8'h54, 8'h84
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] size_sel = '0, sub_idx = '0;
  logic busy, done, ld_ready, ul_valid;
  logic ld_valid = 1'b0, ul_ready = 1'b0;
  logic [15:0] ld_data = '0, ul_data;

  int total = 0, bad = 0;
  bit finished = 0;
  int m [64];
  int got [64];
  int kx [8], ky [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  itx_core dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .size_sel(size_sel),
    .sub_idx(sub_idx), .busy(busy), .done(done), .ld_valid(ld_valid),
    .ld_ready(ld_ready), .ld_data(ld_data), .ul_valid(ul_valid),
    .ul_ready(ul_ready), .ul_data(ul_data)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int pat(input int pid, input int i);
    case (pid)
      0: return (i == 0) ? 512 : 0;
      1: return i * 7 - 200;
      2: return ((i % 2) != 0 ? -1 : 1) * (1000 + i * 13);
      3: return ((i * 37 + 11) % 255) - 127;
      default: return (i % 3 == 0) ? 32767 : ((i % 3 == 1) ? -32768 : 20000);
    endcase
  endfunction

  task automatic kern(input bit w8, input bit col);
    int rnd, sh, lb, e0, e1, e2, e3, o0, o1, o2, o3, p, q;
    rnd = col ? 64 : 4; sh = col ? 7 : 3; lb = (col && w8) ? 1 : 0;
    if (w8) begin
      e0 = 12 * (kx[0] + kx[4]); e1 = 12 * (kx[0] - kx[4]);
      e2 = 16 * kx[2] + 6 * kx[6]; e3 = 6 * kx[2] - 16 * kx[6];
      o0 = 16 * kx[1] + 15 * kx[3] + 9 * kx[5] + 4 * kx[7];
      o1 = 15 * kx[1] - 4 * kx[3] - 16 * kx[5] - 9 * kx[7];
      o2 = 9 * kx[1] - 16 * kx[3] + 4 * kx[5] + 15 * kx[7];
      o3 = 4 * kx[1] - 9 * kx[3] + 15 * kx[5] - 16 * kx[7];
      ky[0] = int'(shortint'((e0 + e2 + o0 + rnd) >>> sh));
      ky[1] = int'(shortint'((e1 + e3 + o1 + rnd) >>> sh));
      ky[2] = int'(shortint'((e1 - e3 + o2 + rnd) >>> sh));
      ky[3] = int'(shortint'((e0 - e2 + o3 + rnd) >>> sh));
      ky[4] = int'(shortint'((e0 - e2 - o3 + rnd + lb) >>> sh));
      ky[5] = int'(shortint'((e1 - e3 - o2 + rnd + lb) >>> sh));
      ky[6] = int'(shortint'((e1 + e3 - o1 + rnd + lb) >>> sh));
      ky[7] = int'(shortint'((e0 + e2 - o0 + rnd + lb) >>> sh));
    end else begin
      p = 17 * (kx[0] + kx[2]); q = 17 * (kx[0] - kx[2]);
      ky[0] = int'(shortint'((p + 22 * kx[1] + 10 * kx[3] + rnd) >>> sh));
      ky[1] = int'(shortint'((q + 10 * kx[1] - 22 * kx[3] + rnd) >>> sh));
      ky[2] = int'(shortint'((q - 10 * kx[1] + 22 * kx[3] + rnd) >>> sh));
      ky[3] = int'(shortint'((p - 22 * kx[1] - 10 * kx[3] + rnd) >>> sh));
    end
  endtask

  task automatic ref_run(input int sz, input int sb, output int h, output int w,
                         output int r0, output int c0);
    h  = (sz % 2 == 1) ? 4 : 8;
    w  = (sz >= 2) ? 4 : 8;
    r0 = (sz == 1) ? 4 * (sb % 2) : ((sz == 3) ? 4 * ((sb / 2) % 2) : 0);
    c0 = (sz >= 2) ? 4 * (sb % 2) : 0;
    for (int l = 0; l < h; l++) begin
      for (int k = 0; k < w; k++) kx[k] = m[(r0 + l) * 8 + c0 + k];
      for (int k = w; k < 8; k++) kx[k] = 0;
      kern(w == 8, 1'b0);
      for (int k = 0; k < w; k++) m[(r0 + l) * 8 + c0 + k] = ky[k];
    end
    for (int l = 0; l < w; l++) begin
      for (int k = 0; k < h; k++) kx[k] = m[(r0 + k) * 8 + c0 + l];
      for (int k = h; k < 8; k++) kx[k] = 0;
      kern(h == 8, 1'b1);
      for (int k = 0; k < h; k++) m[(r0 + k) * 8 + c0 + l] = ky[k];
    end
  endtask

  task automatic run_case(input int sz, input int sb, input int pid, input bit inject);
    int h, w, r0, c0, cnt, n, cyc, prev;
    bit stall;
    string tag;
    // load with gaps
    for (int i = 0; i < 64; i++) begin
      m[i] = int'(shortint'(pat(pid, i)));
      if (i % 9 == 4) begin
        ld_valid = 1'b0; @(posedge clk); @(negedge clk);
      end
      if (i == 0) chk("R1 ready when idle", ld_ready, 1);
      ld_valid = 1'b1; ld_data = 16'(m[i]);
      @(posedge clk); @(negedge clk);
    end
    ld_valid = 1'b0;
    size_sel = 2'(sz); sub_idx = 2'(sb); start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0; cnt = 0;
    while (!done && cnt < 100) begin
      if (inject && cnt == 2) begin
        start = 1'b1; size_sel = 2'd3; sub_idx = 2'd3;
      end else start = 1'b0;
      if (cnt == 1) begin
        chk("R1 ready low while busy", ld_ready, 0);
        chk("R7 busy during passes", busy, 1);
      end
      @(posedge clk); cnt++; @(negedge clk);
    end
    start = 1'b0;
    ref_run(sz, sb, h, w, r0, c0);
    chk(inject ? "R9 done timing after ignored start" : "R7 done timing", cnt, h + w);
    // unload with back-pressure
    n = 0; cyc = 0; stall = 0; prev = 0;
    while (n < 64 && cyc < 1000) begin
      if (stall) chk("R8 held data on stall", int'(ul_data), prev);
      ul_ready = ((cyc % 3) != 1);
      if (n == 5 && inject) start = 1'b1; else start = 1'b0;
      if (n == 3) chk("R1 ready low while unloading", ld_ready, 0);
      stall = ul_valid && !ul_ready;
      prev = int'(ul_data);
      if (ul_valid && ul_ready) begin
        got[n] = int'(shortint'(ul_data)); n++;
      end
      @(posedge clk); cyc++; @(negedge clk);
    end
    ul_ready = 1'b0; start = 1'b0;
    chk("R8 idle after unload: ul_valid", ul_valid, 0);
    chk("R8 idle after unload: ld_ready", ld_ready, 1);
    for (int i = 0; i < 64; i++) begin
      if ((i / 8) >= r0 && (i / 8) < r0 + h && (i % 8) >= c0 && (i % 8) < c0 + w) begin
        if (pid == 4) tag = "R10 wrap result";
        else if (sz == 0) tag = "R2 full block";
        else if (sz == 1) tag = "R3 wide half";
        else if (sz == 2) tag = "R4 tall half";
        else tag = "R5 quarter";
      end else tag = "R6 outside region";
      if (inject) tag = {tag, " R9"};
      chk(tag, got[i], m[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R11 reset busy", busy, 0);
    chk("R11 reset done", done, 0);
    chk("R11 reset ul_valid", ul_valid, 0);
    chk("R11 reset ld_ready", ld_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    for (int v = 0; v < NVEC; v++)
      run_case(int'(VEC[v][7:6]), int'(VEC[v][5:4]), int'(VEC[v][3:0]), 1'b0);
    // directed: start during busy and during unload is ignored
    run_case(0, 0, 3, 1'b1);
    // directed: quarter with both halves, after the previous unload
    run_case(3, 2, 2, 1'b0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule